// File: doc/BRIEF.md
# Interrupt, Halt and Wait Sequencer

This block decides, for an 8-bit processor core, when normal instruction flow gives way to something else. It watches a level-sensitive maskable request line, an edge-triggered non-maskable request line, a halt line and the processor reset. At each instruction boundary reported by the core it chooses one outcome: continue, park the bus, go to sleep after a wait-for-interrupt instruction, or start a service sequence with a fixed vector address.

A service start is a one-cycle request to the core. It carries the even address of the vector pair to fetch, a strobe telling the core to set its interrupt mask bit, and a strobe telling it to begin saving state. The save order is program counter low, program counter high, index low, index high, accumulator A, accumulator B, then condition codes, and the core carries it out. While parked or asleep, the block raises bus-available and forces the valid-address strobe low and read/write to read. The core keeps the next instruction address on the bus during this time.

The request lines are sampled only in cycles where the E phase input is high. The core supplies the current mask bit, an end-of-instruction strobe, and flags that mark the finishing instruction as a wait-for-interrupt or a software interrupt.

Top module: `irq_halt_seq`

## Requirements
- R1: While rst_ni is low, every output is 0. In the first cycle after release, svc_req_o and set_imask_o pulse once, svc_vec_o = 0xFFFE and push_start_o = 0.
- R2: The vector output for a service start is the lower address of its pair: 0xFFFC for the non-maskable request, 0xFFFA for a software interrupt and 0xFFF8 for the maskable request.
- R3: The maskable request is active while irq_ni is low. Its level is captured only in cycles with e_i high, and it is serviced only when imask_i is 0.
- R4: A high-to-low change of nmi_ni, seen across two cycles with e_i high, latches a pending request. It is serviced regardless of imask_i and is cleared when serviced, so a line that stays low does not retrigger.
- R5: When several requests meet at one boundary, the non-maskable request wins over a software interrupt, and a software interrupt wins over the maskable request. Reset overrides all of them asynchronously.
- R6: While running, a service start happens only on the cycle after instr_end_i. From running or from halt release it carries push_start_o = 1 and set_imask_o = 1.
- R7: halt_ni low has no effect until instr_end_i. At that boundary, ba_o, vma_ovr_o and rw_ovr_o go to 1 from the next cycle and stay there while halt_ni stays low. No service starts at that boundary.
- R8: Requests that arrive while halted stay latched. On the first cycle with halt_ni high, a pending one is serviced with saving, and ba_o drops in that same cycle.
- R9: instr_end_i together with wai_i raises ba_o. Only a pending non-maskable request or an unmasked maskable request ends the wait. The wake-up service has push_start_o = 0 and set_imask_o = 1, and ba_o drops with it.
- R10: svc_req_o, set_imask_o and push_start_o are single-cycle pulses per service start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous processor reset |
| e_i | input | 1 | E phase high; request lines are sampled only then |
| irq_ni | input | 1 | Maskable request, active low level |
| nmi_ni | input | 1 | Non-maskable request, falling edge |
| halt_ni | input | 1 | Halt request, active low |
| imask_i | input | 1 | Current interrupt mask bit from the core |
| instr_end_i | input | 1 | Core strobe: instruction completes this cycle |
| wai_i | input | 1 | With instr_end_i: the finishing instruction was wait-for-interrupt |
| swi_i | input | 1 | With instr_end_i: the finishing instruction was a software interrupt |
| svc_req_o | output | 1 | Service start pulse to the core |
| svc_vec_o | output | 16 | Even address of the vector pair to fetch |
| push_start_o | output | 1 | Core must save its registers before the vector fetch |
| set_imask_o | output | 1 | Core must set its mask bit |
| ba_o | output | 1 | Bus available: processor parked or waiting |
| vma_ovr_o | output | 1 | Force valid-address strobe low |
| rw_ovr_o | output | 1 | Force read/write to read |

## Verification
The stimulus covers single requests with the mask clear and with it set, which separates masked from unmasked servicing and shows that the non-maskable path ignores the mask. Glitches driven while E is low show that sampling is gated by the phase, and a non-maskable line held low across two boundaries shows that it is edge-triggered rather than level-triggered. Three requests meeting at one boundary are drained one per boundary, which exposes the priority order. Halt and wait sequences with requests arriving while parked tell saving wake-ups apart from non-saving ones and check when bus-available rises and falls.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
  typedef enum logic [1:0] {ST_BOOT, ST_RUN, ST_HALT, ST_WAIT} seq_st_e;

  localparam int unsigned NUM_SRC = 3;
  // slot index is priority: lower wins
  localparam int unsigned SRC_NMI = 0;
  localparam int unsigned SRC_SWI = 1;
  localparam int unsigned SRC_IRQ = 2;

  localparam logic [15:0] VEC_RST = 16'hFFFE;
  localparam logic [15:0] VEC_NMI = 16'hFFFC;
  localparam logic [15:0] VEC_SWI = 16'hFFFA;
  localparam logic [15:0] VEC_IRQ = 16'hFFF8;
endpackage

// File: rtl/ihs_req_latch.sv
module ihs_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic e_i,
  input  logic irq_ni,
  input  logic nmi_ni,
  input  logic nmi_clr_i,
  output logic nmi_pend_o,
  output logic irq_lvl_o
);
  logic nmi_q;
  logic nmi_fall;

  assign nmi_fall = e_i & nmi_q & ~nmi_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b1;
      irq_lvl_o  <= 1'b0;
      nmi_pend_o <= 1'b0;
    end else begin
      if (e_i) begin
        nmi_q     <= nmi_ni;
        irq_lvl_o <= ~irq_ni;
      end
      // a new edge in the clearing cycle is kept
      nmi_pend_o <= nmi_fall | (nmi_pend_o & ~nmi_clr_i);
    end
  end

  p_nmi_gated_by_e_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_pend_o && !e_i) |=> !nmi_pend_o);
endmodule

// File: rtl/ihs_prio_arb.sv
module ihs_prio_arb #(
  parameter int unsigned NREQ = 3,
  parameter int unsigned AW   = 16
) (
  input  logic [NREQ-1:0]         req_i,
  input  logic [NREQ-1:0][AW-1:0] vec_tab_i,
  output logic                    any_o,
  output logic                    head_gnt_o,
  output logic [AW-1:0]           vec_o
);
  logic [NREQ:0]   blocked;
  logic [NREQ-1:0] gnt;

  assign blocked[0] = 1'b0;
  for (genvar k = 0; k < NREQ; k++) begin : g_chain
    assign gnt[k]       = req_i[k] & ~blocked[k];
    assign blocked[k+1] = blocked[k] | req_i[k];
  end

  assign any_o      = blocked[NREQ];
  assign head_gnt_o = gnt[0];

  always_comb begin
    vec_o = '0;
    for (int k = 0; k < NREQ; k++) begin
      if (gnt[k]) vec_o = vec_o | vec_tab_i[k];
    end
  end
endmodule

// File: rtl/ihs_seq_fsm.sv
module ihs_seq_fsm
  import irq_halt_pkg::*;
#(
  parameter int unsigned   AW      = 16,
  parameter logic [AW-1:0] RST_VEC = VEC_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_end_i,
  input  logic          wai_i,
  input  logic          halt_ni,
  input  logic          any_req_i,
  input  logic          head_gnt_i,
  input  logic [AW-1:0] vec_i,
  output logic          nmi_clr_o,
  output logic          svc_req_o,
  output logic [AW-1:0] svc_vec_o,
  output logic          push_start_o,
  output logic          set_imask_o,
  output logic          ba_o,
  output logic          vma_ovr_o,
  output logic          rw_ovr_o
);
  seq_st_e       st_q, st_n;
  logic          take, take_src, push;
  logic [AW-1:0] vec_n;
  logic          park_n;

  always_comb begin
    st_n     = st_q;
    take     = 1'b0;
    take_src = 1'b0;
    push     = 1'b0;
    vec_n    = vec_i;
    unique case (st_q)
      ST_BOOT: begin
        take  = 1'b1;
        vec_n = RST_VEC;
        st_n  = ST_RUN;
      end
      ST_RUN: begin
        if (instr_end_i) begin
          if (!halt_ni) begin
            st_n = ST_HALT;
          end else if (any_req_i) begin
            take_src = 1'b1;
            push     = 1'b1;
          end else if (wai_i) begin
            st_n = ST_WAIT;
          end
        end
      end
      ST_HALT: begin
        if (halt_ni) begin
          st_n = ST_RUN;
          if (any_req_i) begin
            take_src = 1'b1;
            push     = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        // state already saved by the wait instruction
        if (any_req_i) begin
          take_src = 1'b1;
          st_n     = ST_RUN;
        end
      end
      default: st_n = ST_BOOT;
    endcase
    if (take_src) take = 1'b1;
  end

  assign nmi_clr_o = take_src & head_gnt_i;
  assign park_n    = (st_n == ST_HALT) || (st_n == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_BOOT;
      svc_req_o    <= 1'b0;
      set_imask_o  <= 1'b0;
      push_start_o <= 1'b0;
      svc_vec_o    <= '0;
      ba_o         <= 1'b0;
      vma_ovr_o    <= 1'b0;
      rw_ovr_o     <= 1'b0;
    end else begin
      st_q         <= st_n;
      svc_req_o    <= take;
      set_imask_o  <= take;
      push_start_o <= push;
      if (take) svc_vec_o <= vec_n;
      ba_o         <= park_n;
      vma_ovr_o    <= park_n;
      rw_ovr_o     <= park_n;
    end
  end

  p_boot_vector_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BOOT) |=> (svc_req_o && svc_vec_o == RST_VEC && !push_start_o));

  p_svc_at_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !instr_end_i) |=> !svc_req_o);

  p_park_overrides_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_o |-> (vma_ovr_o && rw_ovr_o));

  p_wake_no_push_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |=> !push_start_o);
endmodule

// File: rtl/irq_halt_seq.sv
module irq_halt_seq
  import irq_halt_pkg::*;
#(
  parameter int unsigned   AW      = 16,
  parameter logic [AW-1:0] RST_VEC = VEC_RST,
  parameter logic [AW-1:0] NMI_VEC = VEC_NMI,
  parameter logic [AW-1:0] SWI_VEC = VEC_SWI,
  parameter logic [AW-1:0] IRQ_VEC = VEC_IRQ
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          e_i,
  input  logic          irq_ni,
  input  logic          nmi_ni,
  input  logic          halt_ni,
  input  logic          imask_i,
  input  logic          instr_end_i,
  input  logic          wai_i,
  input  logic          swi_i,
  output logic          svc_req_o,
  output logic [AW-1:0] svc_vec_o,
  output logic          push_start_o,
  output logic          set_imask_o,
  output logic          ba_o,
  output logic          vma_ovr_o,
  output logic          rw_ovr_o
);
  logic nmi_pend, irq_lvl, nmi_clr;
  logic any_req, head_gnt;
  logic [NUM_SRC-1:0]         req;
  logic [NUM_SRC-1:0][AW-1:0] vec_tab;
  logic [AW-1:0]              vec_sel;

  ihs_req_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .e_i        (e_i),
    .irq_ni     (irq_ni),
    .nmi_ni     (nmi_ni),
    .nmi_clr_i  (nmi_clr),
    .nmi_pend_o (nmi_pend),
    .irq_lvl_o  (irq_lvl)
  );

  always_comb begin
    req          = '0;
    req[SRC_NMI] = nmi_pend;
    req[SRC_SWI] = swi_i & instr_end_i;
    req[SRC_IRQ] = irq_lvl & ~imask_i;
    vec_tab          = '0;
    vec_tab[SRC_NMI] = NMI_VEC;
    vec_tab[SRC_SWI] = SWI_VEC;
    vec_tab[SRC_IRQ] = IRQ_VEC;
  end

  ihs_prio_arb #(.NREQ(NUM_SRC), .AW(AW)) u_arb (
    .req_i      (req),
    .vec_tab_i  (vec_tab),
    .any_o      (any_req),
    .head_gnt_o (head_gnt),
    .vec_o      (vec_sel)
  );

  ihs_seq_fsm #(.AW(AW), .RST_VEC(RST_VEC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .instr_end_i  (instr_end_i),
    .wai_i        (wai_i),
    .halt_ni      (halt_ni),
    .any_req_i    (any_req),
    .head_gnt_i   (head_gnt),
    .vec_i        (vec_sel),
    .nmi_clr_o    (nmi_clr),
    .svc_req_o    (svc_req_o),
    .svc_vec_o    (svc_vec_o),
    .push_start_o (push_start_o),
    .set_imask_o  (set_imask_o),
    .ba_o         (ba_o),
    .vma_ovr_o    (vma_ovr_o),
    .rw_ovr_o     (rw_ovr_o)
  );

  p_irq_unmasked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o && svc_vec_o == IRQ_VEC) |-> !$past(imask_i));
endmodule

// File: tb/irq_halt_seq_test.sv
module irq_halt_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, e, irq_n, nmi_n, halt_n, imask, iend, wai, swi;
  logic svc_req, push, seti, ba, vma_ovr, rw_ovr;
  logic [15:0] vec;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_halt_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .e_i(e), .irq_ni(irq_n), .nmi_ni(nmi_n),
    .halt_ni(halt_n), .imask_i(imask), .instr_end_i(iend), .wai_i(wai),
    .swi_i(swi), .svc_req_o(svc_req), .svc_vec_o(vec), .push_start_o(push),
    .set_imask_o(seti), .ba_o(ba), .vma_ovr_o(vma_ovr), .rw_ovr_o(rw_ovr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_svc(string tag, logic s, logic [15:0] v, logic p);
    chk(tag, "svc_req", {15'd0, svc_req}, {15'd0, s});
    chk(tag, "set_imask", {15'd0, seti}, {15'd0, s});
    chk(tag, "push_start", {15'd0, push}, {15'd0, p});
    if (s) chk(tag, "vector", vec, v);
  endtask

  task automatic chk_park(string tag, logic b);
    chk(tag, "ba", {15'd0, ba}, {15'd0, b});
    chk(tag, "vma_ovr", {15'd0, vma_ovr}, {15'd0, b});
    chk(tag, "rw_ovr", {15'd0, rw_ovr}, {15'd0, b});
  endtask

  task automatic boundary(logic w, logic s);
    iend = 1'b1; wai = w; swi = s;
    tick();
    iend = 1'b0; wai = 1'b0; swi = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; e = 1'b1; irq_n = 1'b1; nmi_n = 1'b1; halt_n = 1'b1;
    imask = 1'b0; iend = 1'b0; wai = 1'b0; swi = 1'b0;
    tick(); tick();
    chk_svc("R1", 1'b0, 16'h0, 1'b0);
    chk_park("R1", 1'b0);
    rst_n = 1'b1;
    tick();
    chk_svc("R1", 1'b1, 16'hFFFE, 1'b0);
    tick();
    chk_svc("R10", 1'b0, 16'h0, 1'b0);
  endtask

  task automatic t_irq();
    imask = 1'b0; irq_n = 1'b0;
    tick();
    chk_svc("R6", 1'b0, 16'h0, 1'b0);
    boundary(1'b0, 1'b0);
    chk_svc("R3", 1'b1, 16'hFFF8, 1'b1);
    imask = 1'b1;
    tick();
    chk_svc("R10", 1'b0, 16'h0, 1'b0);
    boundary(1'b0, 1'b0);
    chk_svc("R3", 1'b0, 16'h0, 1'b0);
    irq_n = 1'b1; imask = 1'b0;
    tick();
  endtask

  task automatic t_e_gate();
    e = 1'b0; irq_n = 1'b0; nmi_n = 1'b0;
    tick();
    irq_n = 1'b1; nmi_n = 1'b1;
    tick();
    e = 1'b1;
    boundary(1'b0, 1'b0);
    chk_svc("R3", 1'b0, 16'h0, 1'b0);
    boundary(1'b0, 1'b0);
    chk_svc("R4", 1'b0, 16'h0, 1'b0);
  endtask

  task automatic t_nmi();
    imask = 1'b1; nmi_n = 1'b0;
    tick();
    boundary(1'b0, 1'b0);
    chk_svc("R4", 1'b1, 16'hFFFC, 1'b1);
    boundary(1'b0, 1'b0);
    chk_svc("R4", 1'b0, 16'h0, 1'b0);
    nmi_n = 1'b1; imask = 1'b0;
    tick();
  endtask

  task automatic t_priority();
    imask = 1'b0; irq_n = 1'b0; nmi_n = 1'b0;
    tick();
    boundary(1'b0, 1'b1);
    chk_svc("R5", 1'b1, 16'hFFFC, 1'b1);
    boundary(1'b0, 1'b1);
    chk_svc("R2", 1'b1, 16'hFFFA, 1'b1);
    boundary(1'b0, 1'b0);
    chk_svc("R5", 1'b1, 16'hFFF8, 1'b1);
    irq_n = 1'b1; nmi_n = 1'b1;
    tick();
  endtask

  task automatic t_halt();
    halt_n = 1'b0;
    tick();
    chk_park("R7", 1'b0);
    boundary(1'b0, 1'b0);
    chk_park("R7", 1'b1);
    chk_svc("R7", 1'b0, 16'h0, 1'b0);
    nmi_n = 1'b0;
    tick();
    nmi_n = 1'b1;
    tick();
    chk_park("R8", 1'b1);
    chk_svc("R8", 1'b0, 16'h0, 1'b0);
    halt_n = 1'b1;
    tick();
    chk_svc("R8", 1'b1, 16'hFFFC, 1'b1);
    chk_park("R8", 1'b0);
  endtask

  task automatic t_wait();
    imask = 1'b1;
    boundary(1'b1, 1'b0);
    chk_park("R9", 1'b1);
    irq_n = 1'b0;
    tick(); tick();
    chk_svc("R9", 1'b0, 16'h0, 1'b0);
    chk_park("R9", 1'b1);
    imask = 1'b0;
    tick();
    chk_svc("R9", 1'b1, 16'hFFF8, 1'b0);
    chk_park("R9", 1'b0);
    irq_n = 1'b1; imask = 1'b1;
    tick();
    boundary(1'b1, 1'b0);
    nmi_n = 1'b0;
    tick();
    chk_park("R9", 1'b1);
    tick();
    chk_svc("R9", 1'b1, 16'hFFFC, 1'b0);
    nmi_n = 1'b1; imask = 1'b0;
    tick();
  endtask

  task automatic t_reset_mid();
    halt_n = 1'b0;
    boundary(1'b0, 1'b0);
    chk_park("R7", 1'b1);
    rst_n = 1'b0;
    #1;
    chk_park("R1", 1'b0);
    halt_n = 1'b1;
    tick();
    rst_n = 1'b1;
    tick();
    chk_svc("R1", 1'b1, 16'hFFFE, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_irq();
    t_e_gate();
    t_nmi();
    t_priority();
    t_halt();
    t_wait();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule